// File: doc/BRIEF.md
# Synchronized Clock-Stop Gate

This block sits on a single output clock and lets an asynchronous, active-low stop request halt that clock cleanly. The request is brought into the clock's own domain through a chain of flops before it has any effect. All gating decisions are taken on the falling edge of the source clock. As a result, the output only ever halts while low, never cuts a high phase short, and its first high phase after a restart is full width. Once the output starts running, it produces a minimum number of complete cycles before a stop is honoured. A request that arrives inside that window is held until the window closes.

A separate active-low power-down input overrides everything else. When it is asserted, the output halts low at the very next falling edge, regardless of the run window. When power-down is released, the output resumes at the next falling edge unless a stop request is still standing. The block keeps no state shared with any other clock. Each output clock that needs stopping gets its own instance, so stopping one clock leaves the others running.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low and `running` is 0.
- R2: After `rst_n` rises with `stop_req_n` and `pwrdn_n` high, `running` becomes 1 at the third falling edge of `clk_in` (SYNC_STAGES+1 edges, default 2 stages). `clk_out` then follows `clk_in` from the next high phase.
- R3: A change of `stop_req_n` is first captured at a falling edge of `clk_in`. It reaches the enable at the SYNC_STAGES-th falling edge after that capture. Release: `running` rises at that edge. Stop, with the run window satisfied: `running` falls at that edge.
- R4: Each time the output starts, it delivers at least MIN_RUN high pulses before a stop request can halt it. A request seen during the window is held, and the output halts right after pulse MIN_RUN. The pulse count for a request raised d input cycles after release is therefore max(d, MIN_RUN).
- R5: Whenever `running` is 0, `clk_out` is 0.
- R6: Every high pulse on `clk_out` lasts exactly one high phase of `clk_in`, including the first pulse after a restart and the last pulse before a stop. `running` changes only while `clk_in` is low.
- R7: When `pwrdn_n` is low at a falling edge of `clk_in`, `running` is 0 after that edge and `clk_out` produces no further pulse. This holds even inside the minimum-run window.
- R8: When `pwrdn_n` returns high and no stop request is standing, `running` returns to 1 at the next falling edge. If `stop_req_n` is still low, the output stays stopped.
- R9: A low pulse on `stop_req_n` that begins and ends between two falling edges of `clk_in` is never captured and has no effect on `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| pwrdn_n | input | 1 | Active-low power-down, acts at the next falling edge |
| clk_out | output | 1 | Gated output clock |
| running | output | 1 | 1 while the gate enable is set |

## Verification
Power-down and a stop request can both land on the same falling edge. The bench lowers both inputs in one step while the output is running. It then releases power-down alone and checks that the standing stop request keeps the output halted with zero pulses. It then releases the stop request and checks that the output resumes after the synchronizer latency. A second collision, a stop request arriving inside the minimum-run window, is swept over every arrival offset from 1 to 12 cycles after release. The counted pulses are compared against max(d, MIN_RUN), and the width of every pulse is measured.

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
  parameter int MIN_RUN     = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic stop_req_n,
  input  logic pwrdn_n,
  output logic clk_out,
  output logic running
);
  localparam int CNT_W = $clog2(MIN_RUN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_RUN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   en_q;
  logic [CNT_W-1:0]       run_cnt;

  wire stop_seen   = ~sync_q[SYNC_STAGES-1];
  wire window_done = (run_cnt >= LAST);
  wire en_d        = pwrdn_n & (en_q ? ~(stop_seen & window_done) : ~stop_seen);

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      en_q    <= 1'b0;
      run_cnt <= '0;
    end else begin
      sync_q <= SYNC_STAGES'({sync_q, stop_req_n});
      en_q   <= en_d;
      if (!en_q)
        run_cnt <= '0;
      else if (!window_done)
        run_cnt <= run_cnt + 1'b1;
    end
  end

  assign clk_out = clk_in & en_q;
  assign running = en_q;
endmodule

module clk_stop_gate_chk #(
  parameter int MIN_RUN = 100
) (
  input logic clk_in,
  input logic rst_n,
  input logic pwrdn_n,
  input logic clk_out,
  input logic running
);
  localparam int CW = $clog2(MIN_RUN + 1);
  logic [CW-1:0] seen;

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n)
      seen <= '0;
    else if (!running)
      seen <= '0;
    else if (seen != CW'(MIN_RUN))
      seen <= seen + 1'b1;
  end

  p_min_run_r4: assert property (@(negedge clk_in) disable iff (!rst_n)
    ($fell(running) && $past(pwrdn_n)) |-> (seen == CW'(MIN_RUN)))
    else $error("minimum run length violated");

  p_pd_stop_r7: assert property (@(negedge clk_in) disable iff (!rst_n)
    !pwrdn_n |=> !running)
    else $error("power-down did not stop the clock");

  always @* begin
    if (rst_n) begin
      p_rest_low_r5: assert (running || !clk_out)
        else $error("stopped clock not low");
    end
  end

  always @(running) begin
    if (rst_n) begin
      p_edge_only_r6: assert (!clk_in)
        else $error("enable changed during high phase");
    end
  end
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.MIN_RUN(MIN_RUN)) u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
  .clk_out(clk_out), .running(running)
);

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/1ps
module clk_stop_gate_tb;
  localparam int MIN_RUN = 6;
  localparam int SYNC    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, stop_req_n = 1'b1, pwrdn_n = 1'b1;
  logic clk_out, running;
  int vectors = 0, errs = 0;
  int pulses = 0, width_err = 0;
  realtime t_rise = 0.0;
  bit done = 0;

  always #10 clk = ~clk;

  clk_stop_gate #(.MIN_RUN(MIN_RUN), .SYNC_STAGES(SYNC)) u_dut (
    .clk_in(clk), .rst_n(rst_n), .stop_req_n(stop_req_n),
    .pwrdn_n(pwrdn_n), .clk_out(clk_out), .running(running));

  always @(posedge clk_out) begin pulses++; t_rise = $realtime; end
  always @(negedge clk_out) if ($realtime - t_rise != 10.0) width_err++;

  task automatic step(); @(posedge clk); #1; endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    check(clk_out == 0, "R1 clk_out in reset", clk_out, 0);
    check(running == 0, "R1 running in reset", running, 0);
    rst_n = 1'b1;
    step(); step();
    check(running == 0, "R2 not yet running", running, 0);
    step();
    check(running == 1, "R2 running after reset", running, 1);
    check(clk_out == 1, "R2 clk_out high phase", clk_out, 1);

    for (int d = 1; d <= 12; d++) begin
      int w0;
      stop_req_n = 1'b0;
      for (int k = 0; k < 40 && running; k++) step();
      check(running == 0 && clk_out == 0, "R5 rest low", clk_out, 0);
      pulses = 0; w0 = width_err;
      stop_req_n = 1'b1;
      for (int i = 1; i <= d; i++) begin
        step();
        if (i == 2) check(running == 0, "R3 release latency early", running, 0);
        if (i == 3) check(running == 1, "R3 release latency", running, 1);
      end
      stop_req_n = 1'b0;
      repeat (d + MIN_RUN + 8) step();
      check(pulses == ((d > MIN_RUN) ? d : MIN_RUN), "R4 pulse count",
            pulses, (d > MIN_RUN) ? d : MIN_RUN);
      check(running == 0, "R3 stopped", running, 0);
      check(width_err == w0, "R6 pulse width", width_err - w0, 0);
    end

    stop_req_n = 1'b1;
    repeat (20) step();
    pulses = 0;
    stop_req_n = 1'b0; #5; stop_req_n = 1'b1;
    repeat (10) step();
    check(pulses == 10, "R9 short stop ignored", pulses, 10);
    check(running == 1, "R9 still running", running, 1);

    pulses = 0;
    pwrdn_n = 1'b0;
    step();
    check(running == 0 && clk_out == 0, "R7 power-down stop", running, 0);
    repeat (5) step();
    check(pulses == 0, "R7 no pulses in power-down", pulses, 0);

    pwrdn_n = 1'b1;
    step();
    check(running == 1 && clk_out == 1, "R8 power-down release", running, 1);
    pwrdn_n = 1'b0;
    step();
    check(running == 0, "R7 power-down inside window", running, 0);

    pwrdn_n = 1'b1;
    repeat (20) step();
    stop_req_n = 1'b0; pwrdn_n = 1'b0;
    step();
    check(running == 0, "R7 collision stop", running, 0);
    step();
    pulses = 0;
    pwrdn_n = 1'b1;
    repeat (10) step();
    check(running == 0 && pulses == 0, "R8 stop holds after power-down", pulses, 0);
    stop_req_n = 1'b1;
    step(); step();
    check(running == 0, "R3 resume latency early", running, 0);
    step();
    check(running == 1, "R3 resume after collision", running, 1);
    check(width_err == 0, "R6 total width errors", width_err, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule